// File: doc/BRIEF.md
# Legacy System Control Port

This block is a byte-wide, I/O-mapped system control register for a legacy PC platform. Firmware and the OS use one control port to gate address line 20, to request a fast alternate CPU reset, to drive an activity LED and to set a CMOS security lock. The same port reports a watchdog timeout and which reset method was last used. The block also decodes a sixteen-port math coprocessor window. There it keeps a busy latch that an external coprocessor-error line sets and that drives the coprocessor interrupt request.

The block has two synchronous, active-low reset inputs. The power-on reset clears everything. The CPU reset clears only the run-time state: the A20 gate, the LED bits and the busy latch. The reset-method flag, the lock and the watchdog flag survive a CPU reset, including a CPU reset that this block's own fast-reset pulse caused. The fast-reset pulse generator runs in the power-on domain only, so a CPU reset cannot cut a pulse short.

Top module: `sysctl_port`

## Requirements
- R1: The control register sits at I/O address 0x0092 and answers only to single-byte accesses (`io_byte`=1). A wide write has no effect. A wide read, and a read of any address that is not decoded, returns 0xFF.
- R2: A byte write of the control register with bit 0 = 1 raises `fast_reset` from the next cycle for exactly PULSE_LEN cycles (default 16). A write with bit 0 = 0 starts no pulse.
- R3: A fast-reset request that arrives while a pulse is running is ignored. The running pulse keeps its original length.
- R4: Bit 1 of a control write drives `a20_gate` from the next cycle. Reading bit 1 returns the current gate state.
- R5: Bit 3 is the CMOS lock and drives `cmos_lock`. Writing 1 sets it. Writing 0 does not clear it. Only the power-on reset clears it.
- R6: Bit 0 reads back as 1 after a fast-reset request. It stays 1 through CPU resets and is cleared only by the power-on reset.
- R7: Bits 7 and 6 are stored and read back. `activity_led` is high whenever either of them is 1.
- R8: Bit 4 is set by a `wdt_timeout` pulse. Writing 0 to bit 4 does not change it. Writing 1 to bit 4 clears it. Bits 5 and 2 always read as 0.
- R9: A CPU reset (`rst_cpu_n`=0) clears the A20 gate, bits 7:6 and the coprocessor busy latch. It keeps bits 0, 3 and 4.
- R10: A `fpu_error` pulse sets the busy latch, and `irq13` rises in the next cycle. The latch stays set until a byte write lands anywhere in 0x00F0 to 0x00FF. A wide write to the window does not clear it. Reads in the window return 0xFF.
- R11: A byte write to 0x00F1 gives a one-cycle `fpu_reset` pulse in the next cycle. Other window addresses give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Synchronous active-low power-on reset |
| rst_cpu_n | input | 1 | Synchronous active-low CPU reset |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_byte | input | 1 | 1 = single-byte access, 0 = wider access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational while `io_rd` is high, 0x00 otherwise) |
| wdt_timeout | input | 1 | Watchdog timeout event |
| fpu_error | input | 1 | Coprocessor error, active high |
| a20_gate | output | 1 | A20 gate enable |
| fast_reset | output | 1 | Fast alternate CPU reset pulse |
| activity_led | output | 1 | Activity LED |
| cmos_lock | output | 1 | CMOS security lock |
| irq13 | output | 1 | Coprocessor-error interrupt request |
| fpu_reset | output | 1 | Coprocessor reset pulse |

## Verification
A wrong lock or reset-method state shows at the ports as a wrong `cmos_lock` level or a wrong bit in the next control-port read. It matters most right after a CPU reset, when a lost sticky bit reads back as 0. A fault in the pulse counter shows as a `fast_reset` pulse of the wrong length, or as a second pulse, within PULSE_LEN cycles of the request. A stuck busy latch shows as `irq13` still high in the first cycle after a byte write to the window.

// File: rtl/sysctl_pkg.sv
// Package: shared constants for the system control port.
// Assumes an 8-bit data lane. The bit positions are visible to software.
package sysctl_pkg;
    localparam int DATA_W     = 8;
    localparam int BIT_METHOD = 0;
    localparam int BIT_A20    = 1;
    localparam int BIT_LOCK   = 3;
    localparam int BIT_WDT    = 4;
    localparam int BIT_LED_LO = 6;
    localparam int BIT_LED_HI = 7;
    localparam logic [DATA_W-1:0] FLOAT_BYTE = 8'hFF;
endpackage

// File: rtl/sysctl_decode.sv
// Module: address decode for the control port and the coprocessor window.
// Assumes each strobe lasts one cycle per access. The outputs are combinational.
module sysctl_decode #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0092,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h00F0,
    parameter int WIN_PORTS = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              is_byte,
    output logic              ctrl_wr,
    output logic              ctrl_rd,
    output logic              win_wr,
    output logic              f1_wr
);
    localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + (ADDR_W+1)'(WIN_PORTS);
    localparam logic [ADDR_W-1:0] RST_ADDR = WIN_BASE + ADDR_W'(1);

    logic ctrl_hit, win_hit;

    // Match the address against the control port and the window range.
    always_comb begin
        ctrl_hit = (addr == CTRL_ADDR);
        win_hit  = ({1'b0, addr} >= {1'b0, WIN_BASE}) && ({1'b0, addr} < WIN_END);
        ctrl_wr  = wr && is_byte && ctrl_hit;
        ctrl_rd  = rd && is_byte && ctrl_hit;
        win_wr   = wr && is_byte && win_hit;
        f1_wr    = wr && is_byte && (addr == RST_ADDR);
    end
endmodule

// File: rtl/sysctl_regs.sv
// Module: control register bits in two reset domains.
// Assumes the two resets are synchronous and active low. The power-on reset
// clears all bits. The CPU reset clears only the gate and the LED bits.
module sysctl_regs
    import sysctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_por_n,
    input  logic              rst_cpu_n,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wdt_event,
    output logic [DATA_W-1:0] status,
    output logic              a20_q,
    output logic              lock_q,
    output logic [1:0]        led_q
);
    logic method_q, wdt_q;
    logic unused_bits;

    assign unused_bits = ^{wdata[5], wdata[2]};

    // Run-time bits: the CPU reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_por_n || !rst_cpu_n) begin
            a20_q <= 1'b0;
            led_q <= 2'b00;
        end else if (ctrl_wr) begin
            a20_q <= wdata[BIT_A20];
            led_q <= wdata[BIT_LED_HI:BIT_LED_LO];
        end
    end

    // Sticky bits: only the power-on reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_por_n) begin
            method_q <= 1'b0;
            lock_q   <= 1'b0;
        end else if (ctrl_wr && rst_cpu_n) begin
            method_q <= method_q | wdata[BIT_METHOD];
            lock_q   <= lock_q | wdata[BIT_LOCK];
        end
    end

    // Watchdog flag: a timeout event sets it and wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_por_n)
            wdt_q <= 1'b0;
        else if (wdt_event)
            wdt_q <= 1'b1;
        else if (ctrl_wr && rst_cpu_n && wdata[BIT_WDT])
            wdt_q <= 1'b0;
    end

    // Assemble the read view of the register.
    always_comb begin
        status = '0;
        status[BIT_METHOD] = method_q;
        status[BIT_A20]    = a20_q;
        status[BIT_LOCK]   = lock_q;
        status[BIT_WDT]    = wdt_q;
        status[BIT_LED_HI:BIT_LED_LO] = led_q;
    end

    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_por_n)
        lock_q |=> lock_q);
    assert_method_sticky_R6: assert property (@(posedge clk) disable iff (!rst_por_n)
        method_q |=> method_q);
    assert_a20_follow_R4: assert property (@(posedge clk) disable iff (!rst_por_n || !rst_cpu_n)
        ctrl_wr |=> (a20_q == $past(wdata[BIT_A20])));
    assert_cpu_rst_clear_R9: assert property (@(posedge clk) disable iff (!rst_por_n)
        !rst_cpu_n |=> (!a20_q && led_q == 2'b00));
endmodule

// File: rtl/sysctl_pulse.sv
// Module: fast-reset pulse generator. A request starts a pulse of PULSE_LEN cycles.
// Runs in the power-on reset domain only, so the CPU reset it causes cannot cut it short.
module sysctl_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_por_n,
    input  logic req,
    output logic pulse
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN);

    logic [CNT_W-1:0] cnt;

    // Load on a request while idle, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_por_n)
            cnt <= '0;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
        else if (req)
            cnt <= LOAD;
    end

    assign pulse = (cnt != '0);

    assert_pulse_start_R2: assert property (@(posedge clk) disable iff (!rst_por_n)
        (req && !pulse) |=> (cnt == LOAD));
    assert_no_retrigger_R3: assert property (@(posedge clk) disable iff (!rst_por_n)
        pulse |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/sysctl_fpu.sv
// Module: coprocessor busy latch and coprocessor reset strobe.
// Assumes fpu_error is synchronous to clk. A set wins over a clear in the same cycle.
module sysctl_fpu (
    input  logic clk,
    input  logic rst_por_n,
    input  logic rst_cpu_n,
    input  logic err,
    input  logic win_wr,
    input  logic f1_wr,
    output logic busy_q,
    output logic rst_pulse_q
);
    // Busy latch: an error sets it, a byte write to the window clears it.
    always_ff @(posedge clk) begin
        if (!rst_por_n || !rst_cpu_n)
            busy_q <= 1'b0;
        else if (err)
            busy_q <= 1'b1;
        else if (win_wr)
            busy_q <= 1'b0;
    end

    // Coprocessor reset: one registered cycle for each write to the reset port.
    always_ff @(posedge clk) begin
        if (!rst_por_n)
            rst_pulse_q <= 1'b0;
        else
            rst_pulse_q <= f1_wr && rst_cpu_n;
    end

    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_por_n || !rst_cpu_n)
        (win_wr && !err) |=> !busy_q);
    assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_por_n || !rst_cpu_n)
        err |=> busy_q);
    assert_fpu_rst_one_R11: assert property (@(posedge clk) disable iff (!rst_por_n)
        rst_pulse_q |=> !rst_pulse_q || $past(f1_wr));
endmodule

// File: rtl/sysctl_port.sv
// Module: top of the legacy system control port. It joins the decode, the register
// bits, the fast-reset pulse and the coprocessor latch, and forms the read data.
// Assumes a byte-wide I/O bus with single-cycle strobes and synchronous resets.
module sysctl_port
    import sysctl_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0092,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h00F0,
    parameter int WIN_PORTS = 16,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_por_n,
    input  logic              rst_cpu_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              io_byte,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              wdt_timeout,
    input  logic              fpu_error,
    output logic              a20_gate,
    output logic              fast_reset,
    output logic              activity_led,
    output logic              cmos_lock,
    output logic              irq13,
    output logic              fpu_reset
);
    logic ctrl_wr, ctrl_rd, win_wr, f1_wr;
    logic [DATA_W-1:0] status;
    logic [1:0] led_q;

    sysctl_decode #(
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .WIN_BASE(WIN_BASE), .WIN_PORTS(WIN_PORTS)
    ) u_decode (
        .addr(io_addr), .rd(io_rd), .wr(io_wr), .is_byte(io_byte),
        .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd), .win_wr(win_wr), .f1_wr(f1_wr)
    );

    sysctl_regs u_regs (
        .clk(clk), .rst_por_n(rst_por_n), .rst_cpu_n(rst_cpu_n),
        .ctrl_wr(ctrl_wr), .wdata(io_wdata), .wdt_event(wdt_timeout),
        .status(status), .a20_q(a20_gate), .lock_q(cmos_lock), .led_q(led_q)
    );

    sysctl_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_por_n(rst_por_n),
        .req(ctrl_wr && rst_cpu_n && io_wdata[BIT_METHOD]),
        .pulse(fast_reset)
    );

    sysctl_fpu u_fpu (
        .clk(clk), .rst_por_n(rst_por_n), .rst_cpu_n(rst_cpu_n),
        .err(fpu_error), .win_wr(win_wr), .f1_wr(f1_wr),
        .busy_q(irq13), .rst_pulse_q(fpu_reset)
    );

    assign activity_led = |led_q;

    // Read data: the register on a byte read of the port, a floating bus on any other read.
    always_comb begin
        if (ctrl_rd)
            io_rdata = status;
        else if (io_rd)
            io_rdata = FLOAT_BYTE;
        else
            io_rdata = '0;
    end

    assert_wide_write_ignored_R1: assert property (@(posedge clk) disable iff (!rst_por_n || !rst_cpu_n)
        (io_wr && !io_byte && !wdt_timeout && !fpu_error) |=> $stable(status) && $stable(irq13));
    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_por_n)
        ctrl_rd |-> (io_rdata[5] == 1'b0 && io_rdata[2] == 1'b0));
endmodule

// File: tb/test_sysctl_port.sv
`timescale 1ns/1ps
module test_sysctl_port;
    logic clk = 1'b0;
    logic rst_por_n = 1'b0, rst_cpu_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic io_rd = 1'b0, io_wr = 1'b0, io_byte = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic wdt_timeout = 1'b0, fpu_error = 1'b0;
    logic a20_gate, fast_reset, activity_led, cmos_lock, irq13, fpu_reset;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sysctl_port i_sysctl_port (
        .clk(clk), .rst_por_n(rst_por_n), .rst_cpu_n(rst_cpu_n),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_byte(io_byte),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .wdt_timeout(wdt_timeout), .fpu_error(fpu_error),
        .a20_gate(a20_gate), .fast_reset(fast_reset), .activity_led(activity_led),
        .cmos_lock(cmos_lock), .irq13(irq13), .fpu_reset(fpu_reset)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic b);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_byte = b; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_byte = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic b, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_byte = b; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0; io_byte = 1'b0;
    endtask

    task automatic pulse_in(input bit wdt, input bit err);
        @(negedge clk);
        wdt_timeout = wdt; fpu_error = err;
        @(negedge clk);
        wdt_timeout = 1'b0; fpu_error = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R6 reset fast_reset", int'(fast_reset), 0);
        check("R4 reset a20", int'(a20_gate), 0);
        check("R10 reset irq13", int'(irq13), 0);
        rd(16'h0092, 1'b1, d);
        check("R6 reset readback", int'(d), 8'h00);
    endtask

    task automatic t_decode();
        logic [7:0] d;
        wr(16'h0092, 8'h02, 1'b0);
        check("R1 wide write ignored", int'(a20_gate), 0);
        wr(16'h0093, 8'h02, 1'b1);
        check("R1 other address ignored", int'(a20_gate), 0);
        rd(16'h0092, 1'b0, d);
        check("R1 wide read all ones", int'(d), 8'hFF);
        rd(16'h0093, 1'b1, d);
        check("R1 undecoded read", int'(d), 8'hFF);
    endtask

    task automatic t_a20();
        logic [7:0] d;
        wr(16'h0092, 8'h02, 1'b1);
        check("R4 a20 on", int'(a20_gate), 1);
        rd(16'h0092, 1'b1, d);
        check("R4 a20 readback", int'(d), 8'h02);
        wr(16'h0092, 8'h00, 1'b1);
        check("R4 a20 off", int'(a20_gate), 0);
    endtask

    task automatic t_led();
        logic [7:0] d;
        wr(16'h0092, 8'h40, 1'b1);
        check("R7 led bit6", int'(activity_led), 1);
        wr(16'h0092, 8'h80, 1'b1);
        check("R7 led bit7", int'(activity_led), 1);
        rd(16'h0092, 1'b1, d);
        check("R7 led readback", int'(d), 8'h80);
        wr(16'h0092, 8'h00, 1'b1);
        check("R7 led off", int'(activity_led), 0);
    endtask

    task automatic t_pulse();
        int n;
        logic [7:0] d;
        wr(16'h0092, 8'h00, 1'b1);
        check("R2 no pulse on bit0=0", int'(fast_reset), 0);
        wr(16'h0092, 8'h01, 1'b1);
        n = 0;
        while (fast_reset && n < 100) begin n++; @(negedge clk); end
        check("R2 pulse length", n, 16);
        wr(16'h0092, 8'h01, 1'b1);
        n = 0;
        while (fast_reset && n < 100) begin
            n++;
            if (n == 5) begin
                io_addr = 16'h0092; io_wdata = 8'h01; io_byte = 1'b1; io_wr = 1'b1;
            end else begin
                io_wr = 1'b0; io_byte = 1'b0;
            end
            @(negedge clk);
        end
        io_wr = 1'b0; io_byte = 1'b0;
        check("R3 retrigger ignored", n, 16);
        repeat (3) @(negedge clk);
        check("R3 no second pulse", int'(fast_reset), 0);
        rd(16'h0092, 1'b1, d);
        check("R6 method flag set", int'(d), 8'h01);
    endtask

    task automatic t_lock();
        wr(16'h0092, 8'h08, 1'b1);
        check("R5 lock set", int'(cmos_lock), 1);
        wr(16'h0092, 8'h00, 1'b1);
        check("R5 lock survives write 0", int'(cmos_lock), 1);
    endtask

    task automatic t_wdt();
        logic [7:0] d;
        pulse_in(1'b1, 1'b0);
        rd(16'h0092, 1'b1, d);
        check("R8 wdt flag set", int'(d), 8'h19);
        wr(16'h0092, 8'h24, 1'b1);
        rd(16'h0092, 1'b1, d);
        check("R8 write0 keeps flag, bits5/2 zero", int'(d), 8'h19);
        wr(16'h0092, 8'h10, 1'b1);
        rd(16'h0092, 1'b1, d);
        check("R8 write1 clears flag", int'(d), 8'h09);
    endtask

    task automatic t_fpu();
        logic [7:0] d;
        pulse_in(1'b0, 1'b1);
        check("R10 irq13 raised", int'(irq13), 1);
        wr(16'h00F4, 8'h00, 1'b0);
        check("R10 wide window write keeps irq", int'(irq13), 1);
        rd(16'h00F3, 1'b1, d);
        check("R10 window read", int'(d), 8'hFF);
        check("R10 read keeps irq", int'(irq13), 1);
        wr(16'h00FF, 8'h00, 1'b1);
        check("R10 write to 0xFF clears irq", int'(irq13), 0);
        pulse_in(1'b0, 1'b1);
        wr(16'h00F0, 8'h00, 1'b1);
        check("R10 write to 0xF0 clears irq", int'(irq13), 0);
    endtask

    task automatic t_f1();
        wr(16'h00F1, 8'h00, 1'b1);
        check("R11 fpu_reset pulse", int'(fpu_reset), 1);
        @(negedge clk);
        check("R11 fpu_reset one cycle", int'(fpu_reset), 0);
        wr(16'h00F2, 8'h00, 1'b1);
        check("R11 no pulse on 0xF2", int'(fpu_reset), 0);
    endtask

    task automatic t_cpu_reset();
        logic [7:0] d;
        wr(16'h0092, 8'hC2, 1'b1);
        pulse_in(1'b1, 1'b1);
        check("R9 prep irq", int'(irq13), 1);
        @(negedge clk); rst_cpu_n = 1'b0;
        @(negedge clk); rst_cpu_n = 1'b1;
        check("R9 a20 cleared", int'(a20_gate), 0);
        check("R9 led cleared", int'(activity_led), 0);
        check("R9 irq cleared", int'(irq13), 0);
        check("R9 lock kept", int'(cmos_lock), 1);
        rd(16'h0092, 1'b1, d);
        check("R6 sticky bits after cpu reset", int'(d), 8'h19);
    endtask

    task automatic t_por();
        logic [7:0] d;
        @(negedge clk); rst_por_n = 1'b0;
        @(negedge clk); rst_por_n = 1'b1;
        check("R5 lock cleared by power-on", int'(cmos_lock), 0);
        rd(16'h0092, 1'b1, d);
        check("R6 power-on clears all", int'(d), 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_por_n = 1'b1; rst_cpu_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_a20();
        t_led();
        t_pulse();
        t_lock();
        t_wdt();
        t_fpu();
        t_f1();
        t_cpu_reset();
        t_por();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule